// File: doc/BRIEF.md
# Dual-Channel Shared-Clock Serial Converter Reader

This block reads a pair of delta-sigma converters wired to a single serial clock pin, each with its own data line. A data line low while the block is idle means that converter has a fresh result. A read is started by a one-cycle `start` pulse, or automatically when `auto_en` is set and both lines are low. The block then issues 24 serial clock pulses and captures one bit per channel before each rising edge, most significant bit first. Both 24-bit words are built in the same shift cycles.

When the read ends, each word is treated as two's complement and widened to 32 bits by copying its top bit. It is then added into that channel's 32-bit accumulator, which wraps on overflow. A one-cycle `done` pulse marks the update. `acc_clr` zeroes both accumulators.

The serial clock is derived from the system clock. Its high phase is `half_div` system clocks. Its low phase is the same length in symmetric mode, or twice as long in asymmetric mode, which gives about one third high. A `hold_req` pulse holds the serial clock high for a multiple of a programmable data-ready period. Five periods resynchronises the converters and twenty-four periods powers them down. The clock then returns low for one low phase before the block accepts new work.

Top module: `dual_adc_reader`

## Requirements
- R1: After reset `sclk`, `busy` and `done` are low and both accumulators read zero. Whenever `busy` is low, `sclk` is low.
- R2: Each read produces exactly 24 rising edges on `sclk`. Both data lines are sampled in the system clock just before each rising edge. The first sample is bit 23 of the word, and each later sample is the next lower bit.
- R3: While idle with `auto_en` high, a read starts when both `sdat_a` and `sdat_b` are low. It does not start if only one is low. With `auto_en` low, the data lines never start a read.
- R4: On completion each accumulator becomes its old value plus the captured word sign-extended from bit 23 to 32 bits, modulo 2^32.
- R5: `done` is high for exactly one cycle per read. In that cycle the accumulators already hold the new sums and `busy` is low.
- R6: With `sym_mode` high, every high phase and every low phase of `sclk` during a read lasts `half_div` system clocks. A `half_div` of 0 acts as 1.
- R7: With `sym_mode` low, every high phase lasts `half_div` system clocks and every low phase lasts twice that.
- R8: `start` pulses and data-ready levels seen while `busy` is high are ignored, so one read still gives 24 edges and one accumulation.
- R9: A `hold_req` pulse while idle with `hold_pd` low holds `sclk` high for 5 × `drdy_period` system clocks, where a period of 0 acts as 1. `sclk` then stays low for one low phase with `busy` high before the block is idle again.
- R10: With `hold_pd` high, the held-high time is 24 × `drdy_period` system clocks, followed by the same low recovery phase.
- R11: `acc_clr` sets both accumulators to zero on the next cycle. It takes priority over an accumulation in the same cycle.
- R12: `hold_req` seen while a read is in progress is ignored, so no high phase is lengthened.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle read request |
| auto_en | input | 1 | Start reads when both data lines signal ready |
| sym_mode | input | 1 | 1: equal high/low phases; 0: low phase twice the high phase |
| half_div | input | DIV_W (8) | High-phase length in system clocks |
| acc_clr | input | 1 | Zero both accumulators |
| hold_req | input | 1 | Begin a long high pulse on the serial clock |
| hold_pd | input | 1 | 0: resynchronise pulse; 1: power-down pulse |
| drdy_period | input | PER_W (12) | Data-ready period in system clocks |
| sclk | output | 1 | Shared serial clock to both converters |
| sdat_a | input | 1 | Data / ready line of channel A |
| sdat_b | input | 1 | Data / ready line of channel B |
| busy | output | 1 | Read, hold or recovery in progress |
| done | output | 1 | One-cycle pulse after accumulation |
| acc_a | output | ACC_W (32) | Channel A running sum |
| acc_b | output | ACC_W (32) | Channel B running sum |

## Verification
The phase-length assertion assumes `half_div` and `sym_mode` stay constant while `busy` is high. The bench changes them only between reads, at idle. The properties also assume the converter model changes a data line only after a rising `sclk` edge or at the start of a read. The bench's model therefore updates its lines a fraction of a system clock after those events. The sweeps cover every configuration of small dividers in both duty modes, and corner words at both sign extremes. A long run of identical words drives both accumulators through their wrap point.

// File: rtl/dual_adc_reader.sv
module dual_adc_reader #(
  parameter int WORD_W    = 24,
  parameter int ACC_W     = 32,
  parameter int DIV_W     = 8,
  parameter int PER_W     = 12,
  parameter int SYNC_MULT = 5,
  parameter int PD_MULT   = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             auto_en,
  input  logic             sym_mode,
  input  logic [DIV_W-1:0] half_div,
  input  logic             acc_clr,
  input  logic             hold_req,
  input  logic             hold_pd,
  input  logic [PER_W-1:0] drdy_period,
  output logic             sclk,
  input  logic             sdat_a,
  input  logic             sdat_b,
  output logic             busy,
  output logic             done,
  output logic [ACC_W-1:0] acc_a,
  output logic [ACC_W-1:0] acc_b
);
  localparam int HOLD_W = PER_W + $clog2(PD_MULT + 1);
  localparam int CNT_W  = (HOLD_W > DIV_W + 1) ? HOLD_W : DIV_W + 1;
  localparam int BIT_W  = $clog2(WORD_W);
  localparam int EXT_W  = ACC_W - WORD_W;

  typedef enum logic [2:0] {S_IDLE, S_LO, S_HI, S_ACC, S_HOLD, S_REC} state_t;

  state_t            state;
  logic [CNT_W-1:0]  cnt;
  logic [BIT_W-1:0]  bitn;
  logic [WORD_W-1:0] sh_a, sh_b;
  logic [DIV_W:0]    hi_len, lo_len;
  logic [PER_W-1:0]  per_eff;
  logic [HOLD_W-1:0] hold_len;
  logic              go;

  assign hi_len   = (half_div == '0) ? (DIV_W+1)'(1) : {1'b0, half_div};
  assign lo_len   = sym_mode ? hi_len : (hi_len << 1);
  assign per_eff  = (drdy_period == '0) ? PER_W'(1) : drdy_period;
  assign hold_len = HOLD_W'(per_eff) * HOLD_W'(hold_pd ? PD_MULT : SYNC_MULT);
  assign go       = start || (auto_en && !sdat_a && !sdat_b);

  assign sclk = (state == S_HI) || (state == S_HOLD);
  assign busy = (state != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      cnt   <= '0;
      bitn  <= '0;
      sh_a  <= '0;
      sh_b  <= '0;
      acc_a <= '0;
      acc_b <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: begin
          if (hold_req) begin
            state <= S_HOLD;
            cnt   <= CNT_W'(hold_len) - CNT_W'(1);
          end else if (go) begin
            state <= S_LO;
            bitn  <= '0;
            cnt   <= CNT_W'(lo_len) - CNT_W'(1);
          end
        end
        S_LO: begin
          if (cnt == '0) begin
            sh_a  <= {sh_a[WORD_W-2:0], sdat_a};
            sh_b  <= {sh_b[WORD_W-2:0], sdat_b};
            state <= S_HI;
            cnt   <= CNT_W'(hi_len) - CNT_W'(1);
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        S_HI: begin
          if (cnt != '0) begin
            cnt <= cnt - CNT_W'(1);
          end else if (bitn == BIT_W'(WORD_W - 1)) begin
            state <= S_ACC;
          end else begin
            bitn  <= bitn + BIT_W'(1);
            state <= S_LO;
            cnt   <= CNT_W'(lo_len) - CNT_W'(1);
          end
        end
        S_ACC: begin
          acc_a <= acc_a + {{EXT_W{sh_a[WORD_W-1]}}, sh_a};
          acc_b <= acc_b + {{EXT_W{sh_b[WORD_W-1]}}, sh_b};
          done  <= 1'b1;
          state <= S_IDLE;
        end
        S_HOLD: begin
          if (cnt == '0) begin
            state <= S_REC;
            cnt   <= CNT_W'(lo_len) - CNT_W'(1);
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        S_REC: begin
          if (cnt == '0) state <= S_IDLE;
          else           cnt   <= cnt - CNT_W'(1);
        end
        default: state <= S_IDLE;
      endcase
      if (acc_clr) begin
        acc_a <= '0;
        acc_b <= '0;
      end
    end
  end

  logic [CNT_W-1:0] hi_run;
  always_ff @(posedge clk) begin
    if (!rst_n)    hi_run <= '0;
    else if (sclk) hi_run <= hi_run + CNT_W'(1);
    else           hi_run <= '0;
  end

  // R1
  idle_clock_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sclk);
  // R2
  edge_in_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> busy);
  // R5
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R5
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R11
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_clr |=> (acc_a == '0 && acc_b == '0));
  // R6
  high_phase_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_HI) |-> (hi_run < CNT_W'(hi_len)));
endmodule

// File: tb/dual_adc_reader_bench.sv
module dual_adc_reader_bench;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n = 1'b0, start = 1'b0, auto_en = 1'b0, sym_mode = 1'b1;
  logic [7:0]  half_div = 8'd1;
  logic        acc_clr = 1'b0, hold_req = 1'b0, hold_pd = 1'b0;
  logic [11:0] drdy_period = 12'd3;
  logic        sclk, busy, done;
  logic        la = 1'b1, lb = 1'b1;
  logic [31:0] acc_a, acc_b;

  dual_adc_reader u_dual_adc_reader (
    .clk(clk), .rst_n(rst_n), .start(start), .auto_en(auto_en),
    .sym_mode(sym_mode), .half_div(half_div), .acc_clr(acc_clr),
    .hold_req(hold_req), .hold_pd(hold_pd), .drdy_period(drdy_period),
    .sclk(sclk), .sdat_a(la), .sdat_b(lb), .busy(busy), .done(done),
    .acc_a(acc_a), .acc_b(acc_b));

  int checks = 0, fails = 0;
  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // converter model: MSB on read start, next bit after each rising sclk
  logic [23:0] wa, wb;
  bit model_on = 0;
  int idx = 0;
  always @(posedge busy) begin
    #1;
    if (model_on) begin idx = 0; la = wa[23]; lb = wb[23]; end
  end
  always @(posedge sclk) begin
    #1;
    if (model_on) begin
      idx++;
      la = (idx < 24) ? wa[23-idx] : 1'b1;
      lb = (idx < 24) ? wb[23-idx] : 1'b1;
    end
  end

  // phase monitor
  int lo_cnt = 0, hi_cnt = 0, rises = 0, bad = 0, exp_hi = 1, exp_lo = 1;
  logic prev_s = 1'b0;
  always @(negedge clk) begin
    if (!busy) begin
      lo_cnt = 0; hi_cnt = 0;
    end else begin
      if (sclk && !prev_s) begin rises++; if (lo_cnt != exp_lo) bad++; lo_cnt = 0; end
      if (!sclk && prev_s) begin if (hi_cnt != exp_hi) bad++; hi_cnt = 0; end
      if (sclk) hi_cnt++; else lo_cnt++;
    end
    prev_s = sclk;
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  logic [31:0] exp_a = 0, exp_b = 0;

  function automatic logic [23:0] word_of(input int k);
    case (k)
      0: return 24'h7FFFFF;
      1: return 24'h800000;
      2: return 24'hFFFFFF;
      3: return 24'h000000;
      4: return 24'h123456;
      default: return 24'(k * 24'h9E3779 + 24'h5A5A5);
    endcase
  endfunction

  task automatic set_cfg(input bit sym, input int half);
    int h;
    h = (half == 0) ? 1 : half;
    sym_mode = sym; half_div = 8'(half);
    exp_hi = h; exp_lo = sym ? h : 2 * h;
  endtask

  task automatic do_read(input logic [23:0] a, input logic [23:0] b,
                         input bit use_auto, input bit spam, input bit clr);
    int n;
    wa = a; wb = b; model_on = 1; bad = 0; rises = 0;
    @(negedge clk);
    if (use_auto) begin auto_en = 1; la = 0; lb = 0; end
    else begin start = 1; @(negedge clk); start = 0; end
    n = 0;
    while (!done && n < 5000) begin
      @(negedge clk);
      if (!done && spam) begin start = 1; hold_req = 1; end
      n++;
    end
    start = 0; hold_req = 0; auto_en = 0;
    if (!clr) begin
      exp_a = exp_a + {{8{a[23]}}, a};
      exp_b = exp_b + {{8{b[23]}}, b};
    end
    chk(acc_a == exp_a, "R4 acc_a", acc_a, exp_a);
    chk(acc_b == exp_b, "R4 acc_b", acc_b, exp_b);
    chk(done && !busy, "R5 done/busy", {done, busy}, 2'b10);
    chk(rises == 24, spam ? "R8 R12 edges" : "R2 edges", rises, 24);
    chk(bad == 0, sym_mode ? "R6 phases" : "R7 phases", bad, 0);
    @(negedge clk);
    chk(!done, "R5 single done", done, 0);
    model_on = 0;
  endtask

  task automatic do_hold(input bit pd, input int per);
    int hc, lc, lowbad;
    drdy_period = 12'(per); hold_pd = pd; exp_hi = 0;
    @(negedge clk); hold_req = 1;
    @(negedge clk); hold_req = 0;
    hc = 0;
    while (sclk && hc < 5000) begin hc++; @(negedge clk); end
    lc = 0; lowbad = 0;
    while (busy && lc < 5000) begin lc++; if (sclk) lowbad++; @(negedge clk); end
    if (pd) chk(hc == 24 * ((per == 0) ? 1 : per), "R10 hold high", hc, 24 * ((per == 0) ? 1 : per));
    else    chk(hc == 5 * ((per == 0) ? 1 : per), "R9 hold high", hc, 5 * ((per == 0) ? 1 : per));
    chk(lc == exp_lo && lowbad == 0, pd ? "R10 recovery" : "R9 recovery", lc, exp_lo);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!sclk && !busy && !done, "R1 idle outputs", {sclk, busy, done}, 0);
    chk(acc_a == 0 && acc_b == 0, "R1 acc reset", acc_a | acc_b, 0);

    // duty sweep over small dividers, corner and scattered words
    for (int s = 0; s < 2; s++)
      for (int h = 0; h < 6; h++) begin
        set_cfg(s[0], h);
        for (int k = 0; k < 6; k++)
          do_read(word_of(k + h), word_of(k + 7), k[0], 1'b0, 1'b0);
      end

    // R3 one line ready, and auto disabled
    begin
      int seen;
      set_cfg(1'b1, 1);
      seen = 0; auto_en = 1; la = 0; lb = 1;
      repeat (20) begin @(negedge clk); if (busy) seen++; end
      chk(seen == 0, "R3 one line low", seen, 0);
      la = 1; lb = 0;
      repeat (20) begin @(negedge clk); if (busy) seen++; end
      chk(seen == 0, "R3 other line low", seen, 0);
      auto_en = 0; la = 0; lb = 0;
      repeat (20) begin @(negedge clk); if (busy) seen++; end
      chk(seen == 0, "R3 auto off", seen, 0);
      la = 1; lb = 1;
      @(negedge clk);
    end

    // R8 R12 starts and holds requested during reads
    set_cfg(1'b0, 2);
    do_read(24'hA5A5A5, 24'h5A5A5A, 1'b0, 1'b1, 1'b0);
    do_read(24'h800001, 24'h7FFFFE, 1'b1, 1'b1, 1'b0);

    // R9 R10 long clock-high pulses
    set_cfg(1'b1, 2);
    do_hold(1'b0, 3);
    do_hold(1'b0, 0);
    set_cfg(1'b0, 3);
    do_hold(1'b1, 2);
    do_hold(1'b1, 5);

    // R11 clear, then clear held across an accumulation
    set_cfg(1'b1, 1);
    @(negedge clk); acc_clr = 1;
    @(negedge clk); acc_clr = 0;
    exp_a = 0; exp_b = 0;
    chk(acc_a == 0 && acc_b == 0, "R11 clear", acc_a | acc_b, 0);
    acc_clr = 1;
    do_read(24'h111111, 24'hEEEEEE, 1'b0, 1'b0, 1'b1);
    acc_clr = 0;
    @(negedge clk);

    // R4 wrap: drive both sums past the 32-bit boundary
    for (int k = 0; k < 260; k++)
      do_read(24'h7FFFFF, 24'h800000, k[0], 1'b0, 1'b0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule